// File: doc/BRIEF.md
# Predicated Structure Memory Access Unit

This unit carries out one memory step of a multi-register structure load or store: it moves a single vector register's worth of bytes between a vector register and memory. The caller supplies a base address, an offset (either a register value scaled by the element size, or a signed immediate counted in whole vector lengths), the element size, the structure member count N and the slot index r of the register being moved. It also supplies the predicate vector and, for stores, the store data. The unit forms the effective address and works out which predicate bit governs each element. Because one predicate bit covers a whole N-member structure, the predicate index is the element's position across all N registers divided by N.

The memory side is a single request/response handshake. A request carries the address, the write flag, the write data and per-byte strobes. A load waits for the response. It then writes the result vector with inactive elements cleared. A store completes once its request is accepted. Address arithmetic wraps at 64 bits, and unaligned addresses go out unchanged.

Top module: `smau_top`

## Requirements
- R1: The request address is base + r × VB + offset, taken modulo 2^64, where VB is the vector length in bytes. The offset is the offset register shifted left by the element-size code when `cmd_use_imm`=0, and the sign-extended immediate × VB when `cmd_use_imm`=1.
- R2: Element size is 1 << `cmd_esz` bytes, E = VB >> `cmd_esz`, and N = `cmd_nm1` + 1. Element i of slot r is governed by predicate bit g = (r·E + i) / N, where bit g of `cmd_pred` is structure g. An element with g ≥ E is inactive, so a slot r ≥ N moves no active elements.
- R3: When a load finishes, `ld_data` holds the response bytes of active elements and zero for every byte of inactive elements.
- R4: A store request has `mem_req_strb` bit k set exactly when byte k lies in an active element. Byte k of `mem_req_wdata` equals the store data for active elements and is zero otherwise.
- R5: A load request has `mem_req_write`=0 and all VB strobe bits set, so every access moves one full vector.
- R6: `mem_req_valid` stays high, with address, data and strobes unchanged, until the cycle in which `mem_req_ready` is high.
- R7: `done` is a single-cycle pulse. For a store it comes in the cycle after acceptance. For a load it comes in the cycle after `mem_rsp_valid`, and `ld_data` changes only at that point. A response that arrives while no load is waiting is ignored.
- R8: `cmd_ready` is high only when the unit is idle. A command offered while the unit is busy is ignored.
- R9: After reset, `cmd_ready`=1, `mem_req_valid`=0, `done`=0 and `ld_data`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Unit idle and accepting |
| cmd_write | input | 1 | 1 = store, 0 = load |
| cmd_esz | input | 2 | Element size code (bytes = 1 << code) |
| cmd_nm1 | input | 2 | Structure member count minus one |
| cmd_slot | input | 2 | Register slot r within the structure |
| cmd_use_imm | input | 1 | Select immediate offset |
| cmd_base | input | 64 | Base address |
| cmd_offreg | input | 64 | Offset register in elements |
| cmd_imm | input | IMM_W | Signed immediate in vector lengths |
| cmd_pred | input | VB | Predicate, one bit per structure |
| cmd_wdata | input | 8·VB | Store data register |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | Request is a write |
| mem_req_addr | output | 64 | Request byte address |
| mem_req_wdata | output | 8·VB | Write data |
| mem_req_strb | output | VB | Byte write enables |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_rdata | input | 8·VB | Read response data |
| done | output | 1 | Micro-op complete pulse |
| ld_data | output | 8·VB | Load result vector |

## Verification
Two events can land in the same cycle. A new command or a stray response can arrive while a request is still waiting for acceptance, and a busy-time command can be offered in the same cycle as a response. The bench provokes both by holding `cmd_valid` high with different fields and pulsing `mem_rsp_valid` with junk data during the stall before `mem_req_ready`. It then judges, on every clock, that the address, strobes, completion timing and final load vector still match its reference model of the original command alone.

// File: rtl/smau_pkg.sv
package smau_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_REQ  = 2'd1,
    PH_WAIT = 2'd2,
    PH_DONE = 2'd3
  } phase_e;

  typedef struct packed {
    logic       write;
    logic [1:0] esz;
    logic [1:0] nm1;
    logic [1:0] slot;
    logic       use_imm;
  } op_ctl_t;
endpackage

// File: rtl/smau_addr_gen.sv
module smau_addr_gen #(
  parameter int ADDR_W = 64,
  parameter int VB     = 16,
  parameter int IMM_W  = 8
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] offreg,
  input  logic [IMM_W-1:0]  imm,
  input  logic              use_imm,
  input  logic [1:0]        esz,
  input  logic [1:0]        slot,
  output logic [ADDR_W-1:0] addr
);
  localparam int VB_LG = $clog2(VB);

  logic [ADDR_W-1:0] slot_term;
  logic [ADDR_W-1:0] imm_ext;
  logic [ADDR_W-1:0] off_term;

  assign slot_term = ADDR_W'(slot) << VB_LG;
  assign imm_ext   = {{(ADDR_W-IMM_W){imm[IMM_W-1]}}, imm};

  always_comb begin
    if (use_imm) off_term = imm_ext << VB_LG;
    else         off_term = offreg << esz;
  end

  assign addr = base + slot_term + off_term;
endmodule

// File: rtl/smau_pred_expand.sv
module smau_pred_expand #(
  parameter int VB = 16
) (
  input  logic [VB-1:0] pred,
  input  logic [1:0]    esz,
  input  logic [1:0]    nm1,
  input  logic [1:0]    slot,
  output logic [VB-1:0] byte_act
);
  localparam int VB_LG = $clog2(VB);
  localparam int IDX_W = VB_LG + 3;

  logic [IDX_W-1:0] ecount;
  logic [IDX_W-1:0] slot_base;

  assign ecount    = IDX_W'(VB) >> esz;
  assign slot_base = IDX_W'(slot) * ecount;

  for (genvar k = 0; k < VB; k++) begin : g_lane
    logic [IDX_W-1:0] elem;
    logic [IDX_W-1:0] pos;
    logic [IDX_W-1:0] grp;

    assign elem = IDX_W'(k) >> esz;
    assign pos  = slot_base + elem;

    always_comb begin
      case (nm1)
        2'd0:    grp = pos;
        2'd1:    grp = pos >> 1;
        2'd2:    grp = pos / IDX_W'(3);
        default: grp = pos >> 2;
      endcase
    end

    assign byte_act[k] = (grp < ecount) && pred[grp[VB_LG-1:0]];
  end
endmodule

// File: rtl/smau_ctrl.sv
module smau_ctrl
  import smau_pkg::*;
(
  input  logic   clk,
  input  logic   rst_sync_n,
  input  logic   cmd_valid,
  input  logic   is_write,
  input  logic   req_ready,
  input  logic   rsp_valid,
  output phase_e phase,
  output logic   accept,
  output logic   load_cap
);
  phase_e phase_nx;

  assign accept   = (phase == PH_IDLE) && cmd_valid;
  assign load_cap = (phase == PH_WAIT) && rsp_valid;

  always_comb begin
    phase_nx = phase;
    case (phase)
      PH_IDLE: if (cmd_valid) phase_nx = PH_REQ;
      PH_REQ:  if (req_ready) phase_nx = is_write ? PH_DONE : PH_WAIT;
      PH_WAIT: if (rsp_valid) phase_nx = PH_DONE;
      default: phase_nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) phase <= PH_IDLE;
    else             phase <= phase_nx;
  end
endmodule

// File: rtl/smau_top.sv
module smau_top
  import smau_pkg::*;
#(
  parameter int VB     = 16,
  parameter int ADDR_W = 64,
  parameter int IMM_W  = 8,
  localparam int DW    = 8 * VB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_write,
  input  logic [1:0]        cmd_esz,
  input  logic [1:0]        cmd_nm1,
  input  logic [1:0]        cmd_slot,
  input  logic              cmd_use_imm,
  input  logic [ADDR_W-1:0] cmd_base,
  input  logic [ADDR_W-1:0] cmd_offreg,
  input  logic [IMM_W-1:0]  cmd_imm,
  input  logic [VB-1:0]     cmd_pred,
  input  logic [DW-1:0]     cmd_wdata,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DW-1:0]     mem_req_wdata,
  output logic [VB-1:0]     mem_req_strb,
  input  logic              mem_rsp_valid,
  input  logic [DW-1:0]     mem_rsp_rdata,
  output logic              done,
  output logic [DW-1:0]     ld_data
);
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  op_ctl_t           q_ctl;
  logic [ADDR_W-1:0] q_base;
  logic [ADDR_W-1:0] q_offreg;
  logic [IMM_W-1:0]  q_imm;
  logic [VB-1:0]     q_pred;
  logic [DW-1:0]     q_wdata;

  phase_e phase;
  logic   accept;
  logic   load_cap;

  smau_ctrl u_ctrl (
    .clk        (clk),
    .rst_sync_n (rst_sync_n),
    .cmd_valid  (cmd_valid),
    .is_write   (q_ctl.write),
    .req_ready  (mem_req_ready),
    .rsp_valid  (mem_rsp_valid),
    .phase      (phase),
    .accept     (accept),
    .load_cap   (load_cap)
  );

  always_ff @(posedge clk) begin
    if (accept) begin
      q_ctl    <= '{write: cmd_write, esz: cmd_esz, nm1: cmd_nm1,
                    slot: cmd_slot, use_imm: cmd_use_imm};
      q_base   <= cmd_base;
      q_offreg <= cmd_offreg;
      q_imm    <= cmd_imm;
      q_pred   <= cmd_pred;
      q_wdata  <= cmd_wdata;
    end
  end

  logic [ADDR_W-1:0] addr_calc;
  logic [VB-1:0]     byte_act;
  logic [DW-1:0]     bit_act;

  smau_addr_gen #(.ADDR_W(ADDR_W), .VB(VB), .IMM_W(IMM_W)) u_addr (
    .base    (q_base),
    .offreg  (q_offreg),
    .imm     (q_imm),
    .use_imm (q_ctl.use_imm),
    .esz     (q_ctl.esz),
    .slot    (q_ctl.slot),
    .addr    (addr_calc)
  );

  smau_pred_expand #(.VB(VB)) u_pred (
    .pred     (q_pred),
    .esz      (q_ctl.esz),
    .nm1      (q_ctl.nm1),
    .slot     (q_ctl.slot),
    .byte_act (byte_act)
  );

  for (genvar k = 0; k < VB; k++) begin : g_bits
    assign bit_act[8*k +: 8] = {8{byte_act[k]}};
  end

  logic [DW-1:0] ld_nx;
  assign ld_nx = mem_rsp_rdata & bit_act;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)   ld_data <= '0;
    else if (load_cap) ld_data <= ld_nx;
  end

  assign cmd_ready     = (phase == PH_IDLE);
  assign mem_req_valid = (phase == PH_REQ);
  assign done          = (phase == PH_DONE);
  assign mem_req_write = q_ctl.write;
  assign mem_req_addr  = addr_calc;
  assign mem_req_strb  = q_ctl.write ? byte_act : {VB{1'b1}};
  assign mem_req_wdata = q_ctl.write ? (q_wdata & bit_act) : '0;
endmodule

// File: rtl/smau_checker.sv
module smau_checker #(
  parameter int VB     = 16,
  parameter int ADDR_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_ready,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_write,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic [8*VB-1:0]   mem_req_wdata,
  input logic [VB-1:0]     mem_req_strb,
  input logic              done,
  input logic [8*VB-1:0]   ld_data
);
  logic [8*VB-1:0] strb_bits;
  for (genvar k = 0; k < VB; k++) begin : g_sb
    assign strb_bits[8*k +: 8] = {8{mem_req_strb[k]}};
  end

  p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_strb) && $stable(mem_req_wdata));

  p_full_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_write |-> (&mem_req_strb));

  p_masked_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_write |-> ((mem_req_wdata & ~strb_bits) == '0));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_ld_only_at_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ld_data) |-> done);

  p_idle_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !mem_req_valid && !done);
endmodule

bind smau_top smau_checker #(.VB(VB), .ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cmd_ready     (cmd_ready),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_write (mem_req_write),
  .mem_req_addr  (mem_req_addr),
  .mem_req_wdata (mem_req_wdata),
  .mem_req_strb  (mem_req_strb),
  .done          (done),
  .ld_data       (ld_data)
);

// File: tb/smau_top_test.sv
`timescale 1ns/1ps
module smau_top_test;
  localparam int VB = 16;
  localparam int AW = 64;
  localparam int IW = 8;
  localparam int DW = 8 * VB;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          cmd_valid = 0, cmd_write = 0, cmd_use_imm = 0;
  logic [1:0]    cmd_esz = 0, cmd_nm1 = 0, cmd_slot = 0;
  logic [AW-1:0] cmd_base = 0, cmd_offreg = 0;
  logic [IW-1:0] cmd_imm = 0;
  logic [VB-1:0] cmd_pred = 0;
  logic [DW-1:0] cmd_wdata = 0;
  logic          mem_req_ready = 0, mem_rsp_valid = 0;
  logic [DW-1:0] mem_rsp_rdata = 0;
  wire           cmd_ready, mem_req_valid, mem_req_write, done;
  wire  [AW-1:0] mem_req_addr;
  wire  [DW-1:0] mem_req_wdata, ld_data;
  wire  [VB-1:0] mem_req_strb;

  smau_top #(.VB(VB), .ADDR_W(AW), .IMM_W(IW)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .cmd_esz(cmd_esz), .cmd_nm1(cmd_nm1),
    .cmd_slot(cmd_slot), .cmd_use_imm(cmd_use_imm), .cmd_base(cmd_base),
    .cmd_offreg(cmd_offreg), .cmd_imm(cmd_imm), .cmd_pred(cmd_pred),
    .cmd_wdata(cmd_wdata), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_write(mem_req_write),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_req_strb(mem_req_strb), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_rdata(mem_rsp_rdata), .done(done), .ld_data(ld_data)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
    end
  endtask

  // Reference: which bytes of the vector are active
  function automatic logic [VB-1:0] ref_act(int esz, int nm1, int slot,
                                            logic [VB-1:0] pred);
    logic [VB-1:0] r;
    int eb, ne, g;
    eb = 1 << esz;
    ne = VB / eb;
    for (int k = 0; k < VB; k++) begin
      g = (slot * ne + k / eb) / (nm1 + 1);
      r[k] = (g < ne) ? pred[g] : 1'b0;
    end
    return r;
  endfunction

  function automatic logic [DW-1:0] ref_mask(logic [VB-1:0] a, logic [DW-1:0] d);
    logic [DW-1:0] r;
    for (int k = 0; k < VB; k++) r[8*k +: 8] = a[k] ? d[8*k +: 8] : 8'h00;
    return r;
  endfunction

  function automatic logic [AW-1:0] ref_addr(logic [AW-1:0] b, logic [AW-1:0] o,
      logic [IW-1:0] im, logic ui, int esz, int slot);
    logic [AW-1:0] off, imx;
    imx = {{(AW-IW){im[IW-1]}}, im};
    off = ui ? imx * AW'(VB) : (o << esz);
    return b + AW'(slot) * AW'(VB) + off;
  endfunction

  // Behavioural reference model
  int            m_phase;
  logic          m_wr, m_ui;
  int            m_esz, m_nm1, m_slot;
  logic [AW-1:0] m_base, m_off;
  logic [IW-1:0] m_imm;
  logic [VB-1:0] m_pred;
  logic [DW-1:0] m_wd, m_ld;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase <= 0;
      m_ld    <= '0;
    end else begin
      case (m_phase)
        0: if (cmd_valid) begin
             m_wr <= cmd_write; m_ui <= cmd_use_imm; m_esz <= cmd_esz;
             m_nm1 <= cmd_nm1; m_slot <= cmd_slot; m_base <= cmd_base;
             m_off <= cmd_offreg; m_imm <= cmd_imm; m_pred <= cmd_pred;
             m_wd <= cmd_wdata; m_phase <= 1;
           end
        1: if (mem_req_ready) m_phase <= m_wr ? 3 : 2;
        2: if (mem_rsp_valid) begin
             m_ld <= ref_mask(ref_act(m_esz, m_nm1, m_slot, m_pred), mem_rsp_rdata);
             m_phase <= 3;
           end
        default: m_phase <= 0;
      endcase
    end
  end

  bit running = 0;
  always @(negedge clk) begin
    if (running) begin
      check("R8 cmd_ready", DW'(cmd_ready), DW'(m_phase == 0));
      check("R6 req_valid", DW'(mem_req_valid), DW'(m_phase == 1));
      check("R7 done", DW'(done), DW'(m_phase == 3));
      check("R3 ld_data", ld_data, m_ld);
      if (m_phase == 1) begin
        check("R1 addr", DW'(mem_req_addr),
              DW'(ref_addr(m_base, m_off, m_imm, m_ui, m_esz, m_slot)));
        check("R5 write flag", DW'(mem_req_write), DW'(m_wr));
        if (m_wr) begin
          check("R2 R4 strobes", DW'(mem_req_strb),
                DW'(ref_act(m_esz, m_nm1, m_slot, m_pred)));
          check("R4 wdata", mem_req_wdata,
                ref_mask(ref_act(m_esz, m_nm1, m_slot, m_pred), m_wd));
        end else begin
          check("R5 full strobes", DW'(mem_req_strb), DW'({VB{1'b1}}));
        end
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic run_op(logic wr, int esz, int nm1, int slot, logic ui,
      logic [AW-1:0] base, logic [AW-1:0] offr, logic [IW-1:0] im,
      logic [VB-1:0] pred, logic [DW-1:0] wd, int rdy_dly, int rsp_dly,
      logic [DW-1:0] rd, bit noise);
    cmd_valid = 1; cmd_write = wr; cmd_esz = 2'(esz); cmd_nm1 = 2'(nm1);
    cmd_slot = 2'(slot); cmd_use_imm = ui; cmd_base = base; cmd_offreg = offr;
    cmd_imm = im; cmd_pred = pred; cmd_wdata = wd;
    step();
    cmd_valid = 0;
    for (int i = 0; i < rdy_dly; i++) begin
      if (noise) begin
        cmd_valid = 1; cmd_write = ~wr; cmd_slot = 2'(slot + 1);
        cmd_base = ~base; cmd_pred = ~pred;
        mem_rsp_valid = 1; mem_rsp_rdata = ~rd;
      end
      step();
    end
    cmd_valid = 0; mem_rsp_valid = 0;
    mem_req_ready = 1;
    step();
    mem_req_ready = 0;
    if (!wr) begin
      for (int i = 0; i < rsp_dly; i++) step();
      mem_rsp_valid = 1; mem_rsp_rdata = rd;
      step();
      mem_rsp_valid = 0; mem_rsp_rdata = '0;
    end
    step(); step();
  endtask

  localparam logic [DW-1:0] PAT_A = 128'h0F1E2D3C4B5A69788796A5B4C3D2E1F0;
  localparam logic [DW-1:0] PAT_B = 128'hDEADBEEF_01234567_89ABCDEF_CAFEF00D;

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) step();
    // R9 reset state
    check("R9 cmd_ready", DW'(cmd_ready), DW'(1));
    check("R9 req_valid", DW'(mem_req_valid), DW'(0));
    check("R9 done", DW'(done), DW'(0));
    check("R9 ld_data", ld_data, '0);
    running = 1;

    // R2 R3: byte loads, pairs, slots 0 and 1
    run_op(0, 0, 1, 0, 0, 64'h1000, 64'h3, 8'h0, 16'hA5C3, '0, 0, 1, PAT_A, 0);
    run_op(0, 0, 1, 1, 0, 64'h1000, 64'h3, 8'h0, 16'hA5C3, '0, 2, 0, PAT_A, 0);
    // R1: negative immediate, halfwords, triples, slot 2
    run_op(0, 1, 2, 2, 1, 64'h8000, 64'h0, 8'hFD, 16'h00B7, '0, 1, 3, PAT_B, 0);
    // R4: word store, quads, slot 3, positive immediate
    run_op(1, 2, 3, 3, 1, 64'h2001, 64'h0, 8'h04, 16'h000B, PAT_A, 1, 0, '0, 0);
    // R4: doubleword store, triples, slot 1, register offset
    run_op(1, 3, 2, 1, 0, 64'h40, 64'h7, 8'h0, 16'h0002, PAT_B, 0, 0, '0, 0);
    // R2: slot beyond N is fully inactive, load and store
    run_op(0, 0, 1, 3, 0, 64'h500, 64'h1, 8'h0, 16'hFFFF, '0, 0, 0, PAT_A, 0);
    run_op(1, 1, 1, 2, 0, 64'h500, 64'h1, 8'h0, 16'hFFFF, PAT_A, 0, 0, '0, 0);
    // N = 1 store, halfwords
    run_op(1, 1, 0, 0, 0, 64'h0, 64'h10, 8'h0, 16'h0069, PAT_B, 0, 0, '0, 0);
    // R1: 64-bit wraparound
    run_op(0, 2, 1, 1, 0, 64'hFFFF_FFFF_FFFF_FFF8, 64'h2, 8'h0, 16'h0006, '0, 0, 2, PAT_B, 0);
    // R7 R8: busy-time command and stray response during request stall
    run_op(0, 0, 3, 2, 1, 64'h9000, 64'h0, 8'h80, 16'h5A3C, '0, 3, 1, PAT_A, 1);
    run_op(1, 0, 2, 0, 0, 64'h123, 64'h5, 8'h0, 16'h0F0F, PAT_A, 3, 0, '0, 1);

    running = 0;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule